// File: doc/BRIEF.md
# Slow-Clock Real-Time Counter with Alarm

This block keeps a 32-bit elapsed-time count that runs in a slow clock domain, nominally 32.768 kHz. A 16-bit programmable divider sits in front of the count. The count advances once each time the divider has seen the programmed number of slow-clock cycles, so a divider of 0x8000 gives one step per second. Software reaches the block through a zero-wait-state APB-style register port that runs on a separate bus clock. Through that port it sets the divider and the interrupt enables, issues a restart, loads a compare value, reads the live count and reads the event flags.

Two event flags live in the slow domain. The tick flag is raised on every count step. The alarm flag is raised when a step lands the count on the compare value. A read of the flag register clears both flags. A restart reloads the divider and zeroes the count. Both of these commands cross into the slow domain through toggle synchronizers, so each one takes effect on the second rising slow-clock edge after the bus transfer that issued it. The live count and the flags cross back to the bus clock through two-stage synchronizers. A multi-bit count can therefore be caught mid-change, and software should read it twice and keep the value when two reads agree.

Top module: `rtt_timer`

## Requirements
- R1: After reset the count reads 0, the flag register reads 0, the compare register reads 0xFFFF_FFFF, the control register reads 0x0000_8000 (divider 0x8000, both enables off) and `irq` is low.
- R2: With divider value P in 1..65535, the count advances by one on every P-th rising slow-clock edge after a restart takes effect. P = 0 divides by 65536. Between steps the count holds.
- R3: The tick flag (bit 0 of the flag register) is set on the slow-clock edge at which the count advances.
- R4: The alarm flag (bit 1 of the flag register) is set on the slow-clock edge at which the count advances to a value equal to the compare register. It is not set on other edges.
- R5: A read of the flag register at offset 0xC returns both flags and clears them on the second rising slow-clock edge after the transfer. If a flag is set on that same edge, it stays set.
- R6: Writing the control register at offset 0x0 with bit 18 set zeroes the count and the divider phase, and loads the divider from bits 15:0, on the second rising slow-clock edge after the write. A divider change written without bit 18 has no effect on counting.
- R7: `irq` is high exactly when (tick flag AND bit 17 of control) OR (alarm flag AND bit 16 of control).
- R8: Register map: control at 0x0 (divider 15:0, alarm enable 16, tick enable 17, restart 18, which always reads 0), compare at 0x4 (read/write), live count at 0x8 (read-only), flags at 0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| sclk | input | 1 | Slow timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Byte address of the register |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data, valid in the access phase |
| irq | output | 1 | Interrupt from the enabled flags |

## Verification
On every cycle the assertions check the following. The count moves only by one step or to zero. The divider phase stays below the loaded divider. A rising tick or alarm flag comes with a count step, and a rising alarm flag matches the compare value. A synchronized restart zeroes the state. Each restart write or flag read flips its command toggle. The restart bit reads as zero, and `irq` stays low when both enables are off. The bench scenarios show what the assertions cannot: the exact two-edge latency of restart and flag clear, the set-wins rule when a clear and a step meet on one edge, the divide-by-65536 case for a zero divider, and the end-to-end count and interrupt values for random dividers, compare values and run lengths.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 4'hC;

  localparam int BIT_EN_ALM  = 16;
  localparam int BIT_EN_TICK = 17;
  localparam int BIT_RESTART = 18;

  localparam int FLAG_TICK = 0;
  localparam int FLAG_ALM  = 1;

  typedef struct packed {
    logic alm;
    logic tick;
  } rtt_flags_t;
endpackage

// File: rtl/rtt_sync.sv
module rtt_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/rtt_core.sv
module rtt_core #(
  parameter int               CNT_W   = 32,
  parameter int               PRE_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_tgl,
  input  logic             clear_tgl,
  input  logic [PRE_W-1:0] presc_new,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tick_flag,
  output logic             alm_flag
);
  logic             rs1_q, rs2_q, cs1_q, cs2_q;
  logic [PRE_W-1:0] presc_q, presc_d;
  logic [PRE_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             alm_q, alm_d;
  logic             restart_now, clear_now, step;
  logic [PRE_W-1:0] last_phase;

  // Command toggles: first stage settles for a full slow period before use.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
      cs1_q <= 1'b0;
      cs2_q <= 1'b0;
    end else begin
      rs1_q <= restart_tgl;
      rs2_q <= rs1_q;
      cs1_q <= clear_tgl;
      cs2_q <= cs1_q;
    end
  end

  assign restart_now = rs1_q ^ rs2_q;
  assign clear_now   = cs1_q ^ cs2_q;
  assign last_phase  = (presc_q == '0) ? '1 : presc_q - 1'b1;

  always_comb begin
    presc_d = presc_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    step    = 1'b0;
    if (restart_now) begin
      presc_d = presc_new;
      phase_d = '0;
      cnt_d   = '0;
    end else begin
      step    = (phase_q == last_phase);
      phase_d = step ? '0 : phase_q + 1'b1;
      cnt_d   = cnt_q + {{(CNT_W-1){1'b0}}, step};
    end
    tick_d = step | (tick_q & ~clear_now);
    alm_d  = (step & (cnt_d == cmp_val)) | (alm_q & ~clear_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PRE_RST;
      phase_q <= '0;
      cnt_q   <= '0;
      tick_q  <= 1'b0;
      alm_q   <= 1'b0;
    end else begin
      presc_q <= presc_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tick_q  <= tick_d;
      alm_q   <= alm_d;
    end
  end

  assign cnt       = cnt_q;
  assign tick_flag = tick_q;
  assign alm_flag  = alm_q;

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));

  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_q != '0) |-> (phase_q < presc_q));

  a_r3_tick_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_q) |-> (cnt_q != $past(cnt_q)));

  a_r4_alarm_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> (cnt_q == cmp_val));

  a_r6_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    restart_now |=> (cnt_q == '0) && (phase_q == '0));
endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               PRE_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt_sync,
  input  rtt_flags_t        flags_sync,
  output logic [PRE_W-1:0]  presc,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              restart_tgl,
  output logic              clear_tgl,
  output logic              irq
);
  logic             wr_en, rd_en;
  logic [PRE_W-1:0] presc_q, presc_d;
  logic             en_alm_q, en_alm_d, en_tick_q, en_tick_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             rst_tgl_q, rst_tgl_d, clr_tgl_q, clr_tgl_d;
  logic             unused_wdata;

  assign wr_en        = psel & penable & pwrite;
  assign rd_en        = psel & penable & ~pwrite;
  assign unused_wdata = ^pwdata;

  always_comb begin
    presc_d   = presc_q;
    en_alm_d  = en_alm_q;
    en_tick_d = en_tick_q;
    cmp_d     = cmp_q;
    rst_tgl_d = rst_tgl_q;
    clr_tgl_d = clr_tgl_q;
    if (wr_en && paddr == ADDR_CTRL) begin
      presc_d   = pwdata[PRE_W-1:0];
      en_alm_d  = pwdata[BIT_EN_ALM];
      en_tick_d = pwdata[BIT_EN_TICK];
      if (pwdata[BIT_RESTART]) rst_tgl_d = ~rst_tgl_q;
    end
    if (wr_en && paddr == ADDR_CMP) cmp_d = pwdata[CNT_W-1:0];
    if (rd_en && paddr == ADDR_FLAGS) clr_tgl_d = ~clr_tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q   <= PRE_RST;
      en_alm_q  <= 1'b0;
      en_tick_q <= 1'b0;
      cmp_q     <= '1;
      rst_tgl_q <= 1'b0;
      clr_tgl_q <= 1'b0;
    end else begin
      presc_q   <= presc_d;
      en_alm_q  <= en_alm_d;
      en_tick_q <= en_tick_d;
      cmp_q     <= cmp_d;
      rst_tgl_q <= rst_tgl_d;
      clr_tgl_q <= clr_tgl_d;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_CTRL: begin
        prdata[PRE_W-1:0]  = presc_q;
        prdata[BIT_EN_ALM]  = en_alm_q;
        prdata[BIT_EN_TICK] = en_tick_q;
      end
      ADDR_CMP:   prdata = DATA_W'(cmp_q);
      ADDR_COUNT: prdata = DATA_W'(cnt_sync);
      ADDR_FLAGS: begin
        prdata[FLAG_TICK] = flags_sync.tick;
        prdata[FLAG_ALM]  = flags_sync.alm;
      end
      default:    prdata = '0;
    endcase
  end

  assign irq         = (flags_sync.tick & en_tick_q) | (flags_sync.alm & en_alm_q);
  assign presc       = presc_q;
  assign cmp_val     = cmp_q;
  assign restart_tgl = rst_tgl_q;
  assign clear_tgl   = clr_tgl_q;

  a_r8_restart_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && paddr == ADDR_CTRL) |-> !prdata[BIT_RESTART]);

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_alm_q && !en_tick_q) |-> !irq);

  a_r6_restart_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && paddr == ADDR_CTRL && pwdata[BIT_RESTART]) |=> (restart_tgl != $past(restart_tgl)));

  a_r5_read_toggles_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && paddr == ADDR_FLAGS) |=> (clear_tgl != $past(clear_tgl)));
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               PRE_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              pclk,
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  localparam int XW = CNT_W + 2;

  logic [1:0]       prst_q, srst_q;
  logic             prst_n, srst_n;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] cmp_val;
  logic             restart_tgl, clear_tgl;
  logic [CNT_W-1:0] cnt_s;
  logic             tick_s, alm_s;
  logic [XW-1:0]    xfer_p;
  rtt_flags_t       flags_p;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) prst_q <= 2'b00;
    else        prst_q <= {prst_q[0], 1'b1};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) srst_q <= 2'b00;
    else        srst_q <= {srst_q[0], 1'b1};
  end

  assign prst_n = prst_q[1];
  assign srst_n = srst_q[1];

  rtt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) i_regs (
    .clk         (pclk),
    .rst_n       (prst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .cnt_sync    (xfer_p[CNT_W-1:0]),
    .flags_sync  (flags_p),
    .presc       (presc),
    .cmp_val     (cmp_val),
    .restart_tgl (restart_tgl),
    .clear_tgl   (clear_tgl),
    .irq         (irq)
  );

  rtt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) i_core (
    .clk         (sclk),
    .rst_n       (srst_n),
    .restart_tgl (restart_tgl),
    .clear_tgl   (clear_tgl),
    .presc_new   (presc),
    .cmp_val     (cmp_val),
    .cnt         (cnt_s),
    .tick_flag   (tick_s),
    .alm_flag    (alm_s)
  );

  rtt_sync #(.WIDTH(XW)) i_back_sync (
    .clk   (pclk),
    .rst_n (prst_n),
    .d     ({alm_s, tick_s, cnt_s}),
    .q     (xfer_p)
  );

  assign flags_p.alm  = xfer_p[CNT_W+1];
  assign flags_p.tick = xfer_p[CNT_W];
endmodule

// File: tb/test_rtt_timer.sv
module test_rtt_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 195000;

  logic        pclk = 1'b0;
  logic        sclk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [3:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference state
  logic [31:0] m_cnt, m_cmp;
  logic [15:0] m_pcnt, m_presc, m_new;
  logic        m_tick, m_alm, m_en_t, m_en_a;
  int          m_rst_pend, m_clr_pend;

  rtt_timer i_rtt_timer (
    .pclk(pclk), .sclk(sclk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  initial begin
    forever begin
      @(posedge pclk);
      cycles++;
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog expired: actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic exp_irq();
    return (m_tick & m_en_t) | (m_alm & m_en_a);
  endfunction

  task automatic model_tick();
    logic        step;
    logic        clr_now;
    logic [15:0] lim;
    clr_now = (m_clr_pend == 1);
    if (m_clr_pend != 0) m_clr_pend--;
    step = 1'b0;
    if (m_rst_pend == 1) begin
      m_cnt = 0; m_pcnt = 0; m_presc = m_new;
    end else begin
      lim    = (m_presc == 0) ? 16'hFFFF : m_presc - 16'd1;
      step   = (m_pcnt == lim);
      m_pcnt = step ? 16'd0 : m_pcnt + 16'd1;
      m_cnt  = m_cnt + {31'd0, step};
    end
    if (m_rst_pend != 0) m_rst_pend--;
    m_tick = step | (m_tick & !clr_now);
    m_alm  = (step && m_cnt == m_cmp) | (m_alm & !clr_now);
  endtask

  task automatic raw_tick();
    @(negedge pclk); sclk = 1'b1;
    @(negedge pclk); sclk = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      raw_tick();
      model_tick();
    end
    repeat (4) @(negedge pclk);
  endtask

  task automatic write_ctrl(input logic [15:0] p, input logic ea, input logic et, input logic rs);
    apb_write(4'h0, {13'd0, rs, et, ea, p});
    m_en_a = ea; m_en_t = et;
    if (rs) begin m_new = p; m_rst_pend = 2; end
  endtask

  task automatic write_cmp(input logic [31:0] v);
    apb_write(4'h4, v);
    m_cmp = v;
  endtask

  task automatic read_flags(input string req);
    logic [31:0] d;
    apb_read(4'hC, d);
    check(req, d, {30'd0, m_alm, m_tick});
    m_clr_pend = 2;
  endtask

  task automatic check_count(input string req);
    logic [31:0] d;
    apb_read(4'h8, d);
    check(req, d, m_cnt);
  endtask

  task automatic check_irq(input string req);
    check(req, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    logic [31:0] d;
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    m_cnt = 0; m_cmp = '1; m_pcnt = 0; m_presc = 16'h8000; m_new = 16'h8000;
    m_tick = 0; m_alm = 0; m_en_t = 0; m_en_a = 0; m_rst_pend = 0; m_clr_pend = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge pclk);
    raw_tick(); raw_tick();
    rst_n = 1'b1;
    repeat (3) raw_tick();
    repeat (4) @(negedge pclk);

    // R1 reset state
    apb_read(4'h8, d); check("R1 count", d, 32'h0);
    apb_read(4'h4, d); check("R1 compare", d, 32'hFFFF_FFFF);
    apb_read(4'h0, d); check("R1 control", d, 32'h0000_8000);
    check("R1 irq", {31'd0, irq}, 32'h0);
    apb_read(4'hC, d); check("R1 flags", d, 32'h0);
    ticks(2);

    // R6 restart latency with divider 3, R8 restart reads zero
    write_ctrl(16'd3, 1'b0, 1'b1, 1'b1);
    apb_read(4'h0, d); check("R8 restart bit reads 0", d, 32'h0002_0003);
    ticks(1); check_count("R6 one edge after restart");
    ticks(1); check_count("R6 zero after second edge");
    ticks(2); check_count("R2 holds before P edges");
    check_irq("R3 no tick yet");
    ticks(1); check_count("R2 step at P edges");
    check_irq("R3 tick flag via irq");

    // R5 clear latency
    read_flags("R5 flags before clear");
    ticks(1); check_irq("R5 flag kept one edge after read");
    ticks(1); check_irq("R5 flag cleared second edge");
    ticks(1); check_irq("R3 tick set on next step");
    // R5 clear meeting a step: step at edge 11 after restart
    ticks(1);
    read_flags("R5 read before coincident step");
    ticks(2); check_irq("R5 set wins over clear");
    check_count("R2 count at coincident step");
    ticks(2);
    read_flags("R5 flags after coincident step");

    // R6 divider change without restart has no effect
    write_ctrl(16'd1, 1'b0, 1'b0, 1'b0);
    ticks(3); check_count("R6 divider change ignored");

    // R4 alarm exact edge with divider 1, R7 alarm enable only
    write_cmp(32'd4);
    write_ctrl(16'd1, 1'b1, 1'b0, 1'b1);
    ticks(5); check_count("R4 count before match");
    check_irq("R4 alarm not yet set");
    ticks(1); check_irq("R4 alarm set at match");
    read_flags("R4 flags at match");
    ticks(2); check_irq("R7 alarm cleared, masked tick");

    // Randomised runs
    for (int it = 0; it < 20; it++) begin
      logic [15:0] p;
      int          n;
      p = 16'($urandom_range(1, 12));
      n = $urandom_range(2, 60);
      write_cmp(32'($urandom_range(0, 12)));
      write_ctrl(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
      ticks(n);
      check_count("R2 random count");
      check_irq("R7 random irq");
      read_flags("R3/R4 random flags");
      ticks(2);
    end

    // R2 zero divider means 65536
    write_ctrl(16'd0, 1'b0, 1'b1, 1'b1);
    ticks(2 + 65535); check_count("R2 zero divider no step at 65535");
    check_irq("R2 zero divider no tick");
    ticks(1); check_count("R2 zero divider step at 65536");
    check_irq("R3 tick at 65536");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule